// File: doc/BRIEF.md
# Dual-Mode Register-Mapped General Timer

A timer peripheral for a simple register bus: an address, a write strobe, 32-bit write data, and read data that follows the address in the same cycle. A configuration register chooses how the single counting resource behaves. In count-down mode the timer counts input clock cycles from a programmed load value and signals a timeout. It then either stops by itself (one-shot) or reloads and runs again (periodic). In clock mode a prescaler divides the input clock down to a once-per-second strobe. That strobe advances a seconds counter, which returns to zero once it would pass a programmed match value.

Events are collected in a raw status register. A mask register selects which raw bits reach the level interrupt output. A separate clear register takes write-one-to-clear commands. In count-down mode each timeout can also produce a one-cycle trigger pulse for other logic.

The software sequence is: program the configuration, mode, load or match and mask registers while the timer is disabled, then set the enable bit. Handle interrupts by reading the masked status and writing the same bits to the clear register.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads 0, and the irq and trig_out outputs are 0.
- R2: The register offsets are: configuration 0x00 (bits 3:0 kept), mode 0x04 (bit 0 kept), control 0x0C (bit 0 = enable, bit 5 = trigger enable, other bits read 0), mask 0x18 (only bits in 0x77 kept), load 0x28 and match 0x30 (32 bits each). The clear register at 0x24 and unmapped offsets read 0.
- R3: With configuration 0 and the enable written from 0 to 1 at clock edge E0, raw status bit 0 becomes set at edge E0+P. P is the load value, and a load of 0 gives P = 1.
- R4: In periodic mode (mode bit 0 = 0) the timer reloads P after each timeout and stays enabled. In one-shot mode (mode bit 0 = 1) a timeout clears control bit 0, and no further timeout follows.
- R5: A control write that leaves the enable bit at 1 does not restart the count. Writing the enable to 0 stops all further timeouts. A later 0-to-1 write starts a full period P.
- R6: trig_out is high for the cycle after each count-down timeout edge if control bit 5 was set at that timeout, and is low otherwise.
- R7: With configuration 1 and the enable set at edge E0, the seconds counter advances at edges E0+k·CLK_HZ. If the incremented value is greater than the match value, the counter becomes 0 instead. Each time it becomes 0, raw status bit 3 is set.
- R8: The value register at 0x48 reads the seconds counter when the configuration is 1, and reads 0 for any other configuration.
- R9: The masked status at 0x20 reads raw AND mask, and irq is high exactly when that value is nonzero. Raw bit 3 cannot be masked in, because mask bit 3 is not writable.
- R10: Writing ones to 0x24 clears those raw status bits. If a timer event sets a bit in the same cycle as a clear of that bit, the bit ends up set.
- R11: With the enable set and any configuration other than 0 or 1, no timer event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: any masked status bit set |
| trig_out | output | 1 | One-cycle pulse after a count-down timeout |

## Verification
The count-down path is run with load values 5, 0, 4 and 8 in both periodic and one-shot modes. Measuring the timeout position distinguishes an off-by-one count and a zero load that never fires from a correct period. A second control write while the timer is running tells a restart apart from a count that continues. The clock mode is run with a match of 2, which separates a counter that wraps past the match from one that stops at it or wraps too early. A timer that reloads every cycle is cleared at the same time as it fires, to show which of set and clear takes priority.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   // register offsets; software depends on these positions
   localparam logic [7:0] OFF_CFG   = 8'h00;
   localparam logic [7:0] OFF_MODE  = 8'h04;
   localparam logic [7:0] OFF_CTL   = 8'h0C;
   localparam logic [7:0] OFF_MASK  = 8'h18;
   localparam logic [7:0] OFF_RAW   = 8'h1C;
   localparam logic [7:0] OFF_MSTAT = 8'h20;
   localparam logic [7:0] OFF_CLR   = 8'h24;
   localparam logic [7:0] OFF_LOAD  = 8'h28;
   localparam logic [7:0] OFF_MATCH = 8'h30;
   localparam logic [7:0] OFF_VALUE = 8'h48;

   localparam int CFG_W = 4;
   localparam logic [CFG_W-1:0] CFG_COUNTDOWN = 4'd0;
   localparam logic [CFG_W-1:0] CFG_SECONDS   = 4'd1;

   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_TRG_BIT = 5;

   localparam int RAW_W = 7;
   localparam logic [RAW_W-1:0] MASK_KEEP = 7'h77;
   localparam int RAW_TMO_BIT = 0;
   localparam int RAW_SEC_BIT = 3;
endpackage

// File: rtl/gtmr_down_cnt.sv
module gtmr_down_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         restart,
   input  logic [W-1:0] period,
   output logic         timeout,
   output logic [W-1:0] count
);
   logic [W-1:0] cnt_q;

   assign timeout = run && !restart && (cnt_q == W'(1));
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= period;
      end else if (run) begin
         cnt_q <= (cnt_q == W'(1)) ? period : cnt_q - W'(1);
      end
   end
endmodule

// File: rtl/gtmr_sec_tick.sv
module gtmr_sec_tick #(
   parameter int CLK_HZ = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic strobe
);
   localparam int PW = (CLK_HZ < 2) ? 1 : $clog2(CLK_HZ);
   localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

   generate
      if (CLK_HZ < 2) begin : g_bad_hz
         $error("gtmr_sec_tick: CLK_HZ must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre_q;

   assign strobe = run && !restart && (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart) begin
         pre_q <= '0;
      end else if (run) begin
         pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
      end
   end
endmodule

// File: rtl/gtmr_rtc_count.sv
module gtmr_rtc_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic [W-1:0] secs,
   output logic         wrap
);
   logic [W-1:0] secs_q, inc, nxt;

   assign inc  = secs_q + W'(1);
   assign nxt  = (inc > limit) ? '0 : inc;
   assign wrap = step && (nxt == '0);
   assign secs = secs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    secs_q <= '0;
      else if (step) secs_q <= nxt;
   end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gtmr_pkg::*;
#(
   parameter int CLK_HZ = 50_000_000,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              trig_out
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("gp_timer: DATA_W must be 32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("gp_timer: ADDR_W must reach offset 0x48");
      end
   endgenerate

   logic                 wr_cfg, wr_mode, wr_ctl, wr_mask, wr_clr, wr_load, wr_match;
   logic [CFG_W-1:0]     cfg_q;
   logic                 oneshot_q, en_q, trg_en_q, trig_q;
   logic [RAW_W-1:0]     mask_q, raw_q, raw_set, clr_bits;
   logic [DATA_W-1:0]    load_q, match_q, period, cd_count, sec_q;
   logic                 restart, run_cd, run_sec, tmo, sec_step, sec_wrap;

   assign wr_cfg   = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
   assign wr_mode  = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
   assign wr_ctl   = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
   assign wr_mask  = bus_we && (bus_addr == ADDR_W'(OFF_MASK));
   assign wr_clr   = bus_we && (bus_addr == ADDR_W'(OFF_CLR));
   assign wr_load  = bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
   assign wr_match = bus_we && (bus_addr == ADDR_W'(OFF_MATCH));

   // only a 0-to-1 enable change restarts timing
   assign restart = wr_ctl && bus_wdata[CTL_EN_BIT] && !en_q;
   assign run_cd  = en_q && (cfg_q == CFG_COUNTDOWN);
   assign run_sec = en_q && (cfg_q == CFG_SECONDS);
   assign period  = (load_q == '0) ? DATA_W'(1) : load_q;

   gtmr_down_cnt #(.W(DATA_W)) u_down (
      .clk(clk), .rst_n(rst_n), .run(run_cd), .restart(restart),
      .period(period), .timeout(tmo), .count(cd_count)
   );

   gtmr_sec_tick #(.CLK_HZ(CLK_HZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_sec), .restart(restart),
      .strobe(sec_step)
   );

   gtmr_rtc_count #(.W(DATA_W)) u_secs (
      .clk(clk), .rst_n(rst_n), .step(sec_step), .limit(match_q),
      .secs(sec_q), .wrap(sec_wrap)
   );

   always_comb begin
      raw_set              = '0;
      raw_set[RAW_TMO_BIT] = tmo;
      raw_set[RAW_SEC_BIT] = sec_wrap;
   end

   assign clr_bits = wr_clr ? bus_wdata[RAW_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         oneshot_q <= 1'b0;
         en_q      <= 1'b0;
         trg_en_q  <= 1'b0;
         mask_q    <= '0;
         raw_q     <= '0;
         load_q    <= '0;
         match_q   <= '0;
         trig_q    <= 1'b0;
      end else begin
         if (wr_cfg)   cfg_q     <= bus_wdata[CFG_W-1:0];
         if (wr_mode)  oneshot_q <= bus_wdata[0];
         if (wr_mask)  mask_q    <= bus_wdata[RAW_W-1:0] & MASK_KEEP;
         if (wr_load)  load_q    <= bus_wdata;
         if (wr_match) match_q   <= bus_wdata;
         if (wr_ctl) begin
            en_q     <= bus_wdata[CTL_EN_BIT];
            trg_en_q <= bus_wdata[CTL_TRG_BIT];
         end else if (tmo && oneshot_q) begin
            en_q <= 1'b0;
         end
         // event set has priority over a simultaneous clear
         raw_q  <= (raw_q & ~clr_bits) | raw_set;
         trig_q <= tmo && trg_en_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_CFG):   bus_rdata[CFG_W-1:0] = cfg_q;
         ADDR_W'(OFF_MODE):  bus_rdata[0]         = oneshot_q;
         ADDR_W'(OFF_CTL): begin
            bus_rdata[CTL_EN_BIT]  = en_q;
            bus_rdata[CTL_TRG_BIT] = trg_en_q;
         end
         ADDR_W'(OFF_MASK):  bus_rdata[RAW_W-1:0] = mask_q;
         ADDR_W'(OFF_RAW):   bus_rdata[RAW_W-1:0] = raw_q;
         ADDR_W'(OFF_MSTAT): bus_rdata[RAW_W-1:0] = raw_q & mask_q;
         ADDR_W'(OFF_LOAD):  bus_rdata            = load_q;
         ADDR_W'(OFF_MATCH): bus_rdata            = match_q;
         ADDR_W'(OFF_VALUE): bus_rdata            = (cfg_q == CFG_SECONDS) ? sec_q : '0;
         default:            bus_rdata            = '0;
      endcase
   end

   assign irq      = |(raw_q & mask_q);
   assign trig_out = trig_q;
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
   import gtmr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              trig_out,
   input logic              tmo,
   input logic              sec_step,
   input logic              en,
   input logic              oneshot,
   input logic              run_cd,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] secs,
   input logic [DATA_W-1:0] match
);
   logic ctl_wr, match_wr;
   assign ctl_wr   = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
   assign match_wr = bus_we && (bus_addr == ADDR_W'(OFF_MATCH));

   assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_CLR)) |-> (bus_rdata == '0));

   assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo && oneshot && !ctl_wr) |=> !en);

   assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cd && cnt != DATA_W'(1) && ctl_wr && bus_wdata[CTL_EN_BIT])
      |=> (cnt == $past(cnt) - DATA_W'(1)));

   assert_trig_follows_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> $past(tmo));

   assert_secs_within_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_step && !match_wr) |=> (secs <= match));

   assert_irq_matches_mstat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_MSTAT)) |-> (irq == (bus_rdata != '0)));
endmodule

bind gp_timer gtmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gtmr_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .trig_out(trig_out),
   .tmo(tmo), .sec_step(sec_step), .en(en_q), .oneshot(oneshot_q),
   .run_cd(run_cd), .cnt(cd_count), .secs(sec_q), .match(match_q)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
   localparam int HZ = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, trig;
   logic        running = 1'b0;
   int          n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   gp_timer #(.CLK_HZ(HZ), .ADDR_W(8), .DATA_W(32)) u_gp_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .trig_out(trig)
   );

   // behavioural reference model
   logic [3:0]  m_cfg;
   logic        m_one, m_en, m_ten, m_trig;
   logic [6:0]  m_mask, m_raw;
   logic [31:0] m_load, m_match, m_cnt, m_sec;
   int          m_pre;

   always @(posedge clk or negedge rst_n) begin
      logic wctl, rs, tout, stp;
      logic [31:0] p, nsec;
      logic [6:0] setb, clrb;
      if (!rst_n) begin
         m_cfg = 0; m_one = 0; m_en = 0; m_ten = 0; m_trig = 0;
         m_mask = 0; m_raw = 0; m_load = 0; m_match = 0; m_cnt = 0; m_sec = 0; m_pre = 0;
      end else begin
         wctl = we && addr == 8'h0C;
         rs   = wctl && wdata[0] && !m_en;
         p    = (m_load == 0) ? 32'd1 : m_load;
         tout = !rs && m_en && m_cfg == 0 && m_cnt == 1;
         stp  = !rs && m_en && m_cfg == 1 && m_pre == HZ - 1;
         nsec = m_sec + 32'd1;
         if (nsec > m_match) nsec = 0;
         setb = 0;
         if (tout) setb[0] = 1'b1;
         if (stp && nsec == 0) setb[3] = 1'b1;
         clrb = (we && addr == 8'h24) ? wdata[6:0] : 7'd0;
         m_trig <= tout && m_ten;
         if (rs) m_cnt <= p;
         else if (m_en && m_cfg == 0) m_cnt <= tout ? p : m_cnt - 32'd1;
         if (rs) m_pre <= 0;
         else if (m_en && m_cfg == 1) m_pre <= (m_pre == HZ - 1) ? 0 : m_pre + 1;
         if (stp) m_sec <= nsec;
         m_raw <= (m_raw & ~clrb) | setb;
         if (wctl) begin m_en <= wdata[0]; m_ten <= wdata[5]; end
         else if (tout && m_one) m_en <= 1'b0;
         if (we && addr == 8'h00) m_cfg <= wdata[3:0];
         if (we && addr == 8'h04) m_one <= wdata[0];
         if (we && addr == 8'h18) m_mask <= wdata[6:0] & 7'h77;
         if (we && addr == 8'h28) m_load <= wdata;
         if (we && addr == 8'h30) m_match <= wdata;
      end
   end

   function automatic logic [31:0] mread(logic [7:0] a);
      case (a)
         8'h00: return {28'd0, m_cfg};
         8'h04: return {31'd0, m_one};
         8'h0C: return {26'd0, m_ten, 4'd0, m_en};
         8'h18: return {25'd0, m_mask};
         8'h1C: return {25'd0, m_raw};
         8'h20: return {25'd0, m_raw & m_mask};
         8'h28: return m_load;
         8'h30: return m_match;
         8'h48: return (m_cfg == 1) ? m_sec : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison of the outputs that do not depend on the address
   always @(negedge clk) begin
      if (rst_n && running) begin
         chk("R9 irq level", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
         chk("R6 trigger pulse", {31'd0, trig}, {31'd0, m_trig});
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, string tag);
      @(negedge clk); we = 1'b0; addr = a; #1;
      chk(tag, rdata, mread(a));
   endtask

   task automatic rdx(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk); we = 1'b0; addr = a; #1;
      chk(tag, rdata, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic poll_tmo(int exp, string tag);
      int seen = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk); addr = 8'h1C; #1;
         if (rdata[0] && seen == 0) seen = i;
      end
      chk(tag, seen, exp);
   endtask

   task automatic finish_run();
      running = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      // R1 reset state
      rdx(8'h00, 0, "R1 cfg reset"); rdx(8'h0C, 0, "R1 ctl reset");
      rdx(8'h18, 0, "R1 mask reset"); rdx(8'h1C, 0, "R1 raw reset");
      rdx(8'h28, 0, "R1 load reset"); rdx(8'h30, 0, "R1 match reset");
      chk("R1 outputs low", {30'd0, irq, trig}, 0);
      // R2 register map
      wr(8'h00, 32'hFFFF_FFF3); rdx(8'h00, 32'h3, "R2 cfg width");
      wr(8'h04, 32'hFF);        rdx(8'h04, 32'h1, "R2 mode width");
      wr(8'h18, 32'hFF);        rdx(8'h18, 32'h77, "R2 mask writable bits");
      wr(8'h28, 32'hDEAD_BEEF); rdx(8'h28, 32'hDEAD_BEEF, "R2 load");
      wr(8'h30, 32'h1234_5678); rdx(8'h30, 32'h1234_5678, "R2 match");
      rdx(8'h10, 0, "R2 unmapped"); rdx(8'h24, 0, "R2 clear reads 0");
      wr(8'h0C, 32'hFFFF_FFFF); rdx(8'h0C, 32'h21, "R2 ctl bits");
      // R11 no events in other configurations
      idle(30);
      rdx(8'h1C, 0, "R11 no events with cfg 3");
      rdx(8'h48, 0, "R8 value outside clock mode");
      wr(8'h0C, 0);
      // R3 countdown period
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h18, 1); wr(8'h24, 32'hFF);
      wr(8'h28, 5); wr(8'h0C, 1);
      poll_tmo(5, "R3 load 5 period");
      wr(8'h0C, 0); wr(8'h24, 1); wr(8'h28, 0); wr(8'h0C, 1);
      poll_tmo(1, "R3 load 0 acts as 1");
      // R4 periodic with trigger
      wr(8'h0C, 0); wr(8'h28, 4); wr(8'h24, 1); wr(8'h0C, 32'h21);
      idle(20);
      rdx(8'h0C, 32'h21, "R4 periodic stays enabled");
      rd(8'h1C, "R4 periodic raw");
      // R4 one-shot
      wr(8'h0C, 0); wr(8'h04, 1); wr(8'h24, 1); wr(8'h0C, 32'h21);
      idle(10);
      rdx(8'h0C, 32'h20, "R4 one-shot clears enable");
      rdx(8'h1C, 1, "R4 one-shot timeout seen");
      wr(8'h24, 1); idle(10);
      rdx(8'h1C, 0, "R4 one-shot no second timeout");
      // R5 restart rules
      wr(8'h04, 0); wr(8'h28, 8); wr(8'h0C, 1); wr(8'h0C, 1);
      poll_tmo(6, "R5 same-value write keeps count");
      wr(8'h0C, 0); wr(8'h24, 1); idle(20);
      rdx(8'h1C, 0, "R5 disable stops timeouts");
      wr(8'h0C, 1);
      poll_tmo(8, "R5 re-enable gives full period");
      // R10 set beats clear, R9 masked status
      wr(8'h0C, 0); wr(8'h28, 0); wr(8'h0C, 1);
      wr(8'h24, 1);
      rdx(8'h1C, 1, "R10 set wins over clear");
      wr(8'h18, 0); rdx(8'h20, 0, "R9 masked off");
      wr(8'h18, 1); rdx(8'h20, 1, "R9 masked on");
      wr(8'h0C, 0); wr(8'h24, 32'hFF);
      rdx(8'h1C, 0, "R10 clear works");
      // R7 / R8 clock mode
      wr(8'h00, 1); wr(8'h30, 2); wr(8'h0C, 1);
      for (int i = 1; i <= 20; i++) begin
         logic [31:0] e;
         e = (i < 6) ? 0 : (i < 12) ? 1 : (i < 18) ? 2 : 0;
         @(negedge clk); addr = 8'h48; #1;
         chk("R7 seconds sequence", rdata, e);
      end
      rdx(8'h1C, 8, "R7 wrap sets raw bit 3");
      chk("R9 bit 3 not maskable", {31'd0, irq}, 0);
      rd(8'h48, "R8 value in clock mode");
      wr(8'h0C, 0); wr(8'h00, 0);
      rdx(8'h48, 0, "R8 value reads 0 in countdown");
      idle(3);
      finish_run();
   end
endmodule